// File: doc/BRIEF.md
# Buffered Flash Program Command Sequencer

This block is the command front end of a NOR-style flash device for buffered programming. The host issues bus writes, each carrying an address, a data word and a write strobe. A program run is a fixed sequence of writes. First comes a setup opcode written to any address in the target erase block. The next write gives a word count. Then the first data word arrives at the start address, further data words follow at addresses of the host's choice inside the run, and a confirm opcode ends the sequence. The data words are held in a write buffer. After a valid confirm the block copies them one word at a time into an internal array model, taking a fixed number of clock cycles per word.

Every step is checked. A wrong command at the confirm step, a data address outside the declared run, a run that would leave its erase block, a run that exceeds the buffer capacity, and an active programming-voltage lockout flag each abort the run and set error bits in an 8-bit status word. An injected array failure during the copy also stops the run and sets an error bit. The error bits stay set until the host clears them. The host reads the status word at all times and can read the array through a separate read port.

Top module: `bufprog_seq`

## Requirements
- R1: After reset the status word reads 0x80. Bit 7 is ready (1 when idle, 0 while copying), bit 5 is the sequence error, bit 4 is the program error and bit 3 is the voltage error. Bits 6, 2, 1 and 0 always read 0.
- R2: The run proceeds as follows. Opcode 0xE8 (data bits 7:0) is written to an address in block B. The next write's data bits 8:0 hold N-1. The next write carries the start address S and the first word. N-1 further writes follow, each at an address in [S, S+N-1]. Opcode 0xD0 is then written to any address in block B. After the copy, array word S+k holds the last data written to offset k, and offsets that received no write leave their array word unchanged.
- R3: Ready reads 0 for exactly N×PROG_CYCLES cycles, starting the cycle after the accepted confirm. Host writes during that time are ignored.
- R4: At the confirm step, data other than 0xD0, or 0xD0 written outside block B, sets bits 5 and 4 (status 0xB0). The array is left unchanged and the block returns to idle.
- R5: A data write whose address is outside [S, S+N-1] sets bits 5 and 4 at once and aborts the run.
- R6: If S lies outside block B, or S+N-1 lies beyond the end of block B, the run aborts and sets bits 5 and 4.
- R7: Let L be bits 8:0 of S. If L+N-1 ≥ 512 and N > 256, the run aborts and sets bits 5 and 4. An aligned run of 512 words, and an unaligned run of 256 words that crosses a 512-word boundary, are both accepted.
- R8: If the lockout input is 1 when the setup opcode is written in idle, bits 4 and 3 are set and the block stays idle.
- R9: If the fail input is 1 at the cycle a word would be committed, that word is not written, bit 4 is set and the block returns to ready. This happens PROG_CYCLES cycles after confirm for the first word.
- R10: Bits 5, 4 and 3 stay set until opcode 0x50 is written in idle, which clears all three. A 0x50 written while copying has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Host write word address |
| wr_data | input | DATA_W | Host write data or opcode |
| vpp_lock | input | 1 | Programming-voltage lockout flag |
| fail_inject | input | 1 | Forces the word being committed to fail |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data, one cycle after rd_addr |
| status | output | 8 | Status word |

## Verification
A sequencer stuck in the wrong step shows up on the status word at the next host write. A missed abort leaves status at 0x80 when 0xB0 is due, and a skipped step makes the confirm land as data, so ready never drops. An error in the buffer offset or the copy counter shows up only at the read port after the run, as a wrong word at S+k or a changed neighbour, so every run is read back at its first, last and interior addresses. A wrong per-word timer changes the count of busy cycles, which the bench counts exactly for each run.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;

    localparam logic [7:0] OP_SETUP   = 8'hE8;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_CLRSR   = 8'h50;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FIRST,
        ST_DATA,
        ST_CONFIRM,
        ST_PROG
    } seq_state_t;

    typedef struct packed {
        logic ready;
        logic seq_err;
        logic prog_err;
        logic vpp_err;
    } sr_t;

    function automatic logic [7:0] pack_status(input sr_t s);
        return {s.ready, 1'b0, s.seq_err, s.prog_err, s.vpp_err, 3'b000};
    endfunction

    // an unaligned run that crosses a buffer-sized boundary may hold only half the buffer
    function automatic logic cap_violation(input int unsigned low,
                                           input int unsigned cnt_m1,
                                           input int unsigned words);
        return ((low + cnt_m1) >= words) && (cnt_m1 >= (words / 2));
    endfunction

endpackage

// File: rtl/bufprog_wbuf.sv
module bufprog_wbuf #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic [IDX_W-1:0]  r_idx,
    output logic [DATA_W-1:0] r_data,
    output logic              r_valid
);
    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  filled;

    always_ff @(posedge clk) begin
        if (we) mem[w_idx] <= w_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) filled <= '0;
        else if (we)    filled[w_idx] <= 1'b1;
    end

    assign r_data  = mem[r_idx];
    assign r_valid = filled[r_idx];
endmodule

// File: rtl/bufprog_array.sv
module bufprog_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [DATA_W-1:0] w_data,
    input  logic [ADDR_W-1:0] r_addr,
    output logic [DATA_W-1:0] r_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[w_addr] <= w_data;
        r_data <= cells[r_addr];
    end
endmodule

// File: rtl/bufprog_ctrl.sv
module bufprog_ctrl
    import bufprog_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 16,
    parameter int IDX_W       = 9,
    parameter int BLK_LSB     = 10,
    parameter int PROG_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vpp_lock,
    input  logic              fail_inject,
    output logic              buf_clr,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic [DATA_W-1:0] buf_wdata,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              slot_valid,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        status,
    output seq_state_t        state_o,
    output logic              commit_o
);
    localparam int BUF_WORDS = 1 << IDX_W;
    localparam int BLK_W     = ADDR_W - BLK_LSB;
    localparam int CYC_W     = $clog2(PROG_CYCLES + 1);

    seq_state_t        state;
    logic [BLK_W-1:0]  blk_q;
    logic [IDX_W-1:0]  cnt_m1;
    logic [ADDR_W-1:0] start_q;
    logic [IDX_W-1:0]  recv;
    logic [IDX_W-1:0]  pidx;
    logic [CYC_W-1:0]  cyc;
    logic              seq_err_q, prog_err_q, vpp_err_q;

    logic [7:0]        cmd;
    logic [ADDR_W:0]   end_w;
    logic [ADDR_W-1:0] off_w;
    logic              blk_bad, cap_bad, in_rng, same_blk, commit;
    sr_t               sr;

    always_comb begin
        cmd      = wr_data[7:0];
        same_blk = (wr_addr[ADDR_W-1:BLK_LSB] == blk_q);
        end_w    = {1'b0, wr_addr} + (ADDR_W+1)'(cnt_m1);
        blk_bad  = !same_blk || (end_w[ADDR_W:BLK_LSB] != {1'b0, blk_q});
        cap_bad  = cap_violation(32'(wr_addr[IDX_W-1:0]), 32'(cnt_m1), BUF_WORDS);
        off_w    = wr_addr - start_q;
        in_rng   = (wr_addr >= start_q) && (off_w <= ADDR_W'(cnt_m1));
        commit   = (state == ST_PROG) && (cyc == CYC_W'(PROG_CYCLES - 1));
    end

    assign buf_clr   = wr_en && (state == ST_COUNT);
    assign buf_we    = wr_en && (((state == ST_FIRST) && !blk_bad && !cap_bad) ||
                                 ((state == ST_DATA) && in_rng));
    assign buf_idx   = (state == ST_FIRST) ? '0 : off_w[IDX_W-1:0];
    assign buf_wdata = wr_data;
    assign rd_idx    = pidx;
    assign arr_we    = commit && slot_valid && !fail_inject;
    assign arr_addr  = start_q + ADDR_W'(pidx);
    assign state_o   = state;
    assign commit_o  = commit;

    always_comb begin
        sr.ready    = (state != ST_PROG);
        sr.seq_err  = seq_err_q;
        sr.prog_err = prog_err_q;
        sr.vpp_err  = vpp_err_q;
        status      = pack_status(sr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            blk_q      <= '0;
            cnt_m1     <= '0;
            start_q    <= '0;
            recv       <= '0;
            pidx       <= '0;
            cyc        <= '0;
            seq_err_q  <= 1'b0;
            prog_err_q <= 1'b0;
            vpp_err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (wr_en) begin
                    if (cmd == OP_SETUP) begin
                        if (vpp_lock) begin
                            vpp_err_q  <= 1'b1;
                            prog_err_q <= 1'b1;
                        end else begin
                            blk_q <= wr_addr[ADDR_W-1:BLK_LSB];
                            state <= ST_COUNT;
                        end
                    end else if (cmd == OP_CLRSR) begin
                        seq_err_q  <= 1'b0;
                        prog_err_q <= 1'b0;
                        vpp_err_q  <= 1'b0;
                    end
                end
                ST_COUNT: if (wr_en) begin
                    cnt_m1 <= wr_data[IDX_W-1:0];
                    state  <= ST_FIRST;
                end
                ST_FIRST: if (wr_en) begin
                    if (blk_bad || cap_bad) begin
                        seq_err_q  <= 1'b1;
                        prog_err_q <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        start_q <= wr_addr;
                        recv    <= IDX_W'(1);
                        state   <= (cnt_m1 == '0) ? ST_CONFIRM : ST_DATA;
                    end
                end
                ST_DATA: if (wr_en) begin
                    if (!in_rng) begin
                        seq_err_q  <= 1'b1;
                        prog_err_q <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        recv <= recv + 1'b1;
                        if (recv == cnt_m1) state <= ST_CONFIRM;
                    end
                end
                ST_CONFIRM: if (wr_en) begin
                    if ((cmd == OP_CONFIRM) && same_blk) begin
                        pidx  <= '0;
                        cyc   <= '0;
                        state <= ST_PROG;
                    end else begin
                        seq_err_q  <= 1'b1;
                        prog_err_q <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                ST_PROG: begin
                    if (commit) begin
                        cyc <= '0;
                        if (fail_inject) begin
                            prog_err_q <= 1'b1;
                            state      <= ST_IDLE;
                        end else if (pidx == cnt_m1) begin
                            state <= ST_IDLE;
                        end else begin
                            pidx <= pidx + 1'b1;
                        end
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bufprog_seq.sv
module bufprog_seq
    import bufprog_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 16,
    parameter int BUF_WORDS   = 512,
    parameter int BLOCK_WORDS = 1024,
    parameter int PROG_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vpp_lock,
    input  logic              fail_inject,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        status
);
    localparam int IDX_W   = $clog2(BUF_WORDS);
    localparam int BLK_LSB = $clog2(BLOCK_WORDS);

    logic              buf_clr, buf_we, slot_valid, arr_we;
    logic [IDX_W-1:0]  buf_idx, rd_idx;
    logic [DATA_W-1:0] buf_wdata, buf_rdata;
    logic [ADDR_W-1:0] arr_addr;
    seq_state_t        seq_state;
    logic              seq_commit;

    bufprog_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .BLK_LSB(BLK_LSB), .PROG_CYCLES(PROG_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vpp_lock(vpp_lock), .fail_inject(fail_inject),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .rd_idx(rd_idx), .slot_valid(slot_valid),
        .arr_we(arr_we), .arr_addr(arr_addr), .status(status),
        .state_o(seq_state), .commit_o(seq_commit)
    );

    bufprog_wbuf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wbuf (
        .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .w_idx(buf_idx),
        .w_data(buf_wdata), .r_idx(rd_idx), .r_data(buf_rdata), .r_valid(slot_valid)
    );

    bufprog_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .we(arr_we), .w_addr(arr_addr), .w_data(buf_rdata),
        .r_addr(rd_addr), .r_data(rd_data)
    );
endmodule

// File: rtl/bufprog_seq_chk.sv
module bufprog_seq_chk
    import bufprog_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] cmd,
    input logic       vpp_lock,
    input logic       fail_inject,
    input logic [7:0] status,
    input seq_state_t state,
    input logic       commit
);
    logic clr_now;
    assign clr_now = (state == ST_IDLE) && wr_en && (cmd == OP_CLRSR);

    a_r1_reset_status: assert property (@(posedge clk)
        $past(rst) |-> (status == 8'h80));

    a_r10_sticky_seq: assert property (@(posedge clk) disable iff (rst)
        (status[5] && !clr_now) |=> status[5]);

    a_r10_sticky_prog: assert property (@(posedge clk) disable iff (rst)
        (status[4] && !clr_now) |=> status[4]);

    a_r10_sticky_vpp: assert property (@(posedge clk) disable iff (rst)
        (status[3] && !clr_now) |=> status[3]);

    a_r4_bad_confirm: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONFIRM && wr_en && cmd != OP_CONFIRM)
        |=> (status[7] && status[5] && status[4] && state == ST_IDLE));

    a_r8_vpp_lock: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && wr_en && cmd == OP_SETUP && vpp_lock)
        |=> (status[4] && status[3] && state == ST_IDLE));

    a_r9_fail_stop: assert property (@(posedge clk) disable iff (rst)
        (commit && fail_inject) |=> (status[7] && status[4]));

    a_r3_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG && !commit) |=> (state == ST_PROG && !status[7]));
endmodule

bind bufprog_seq bufprog_seq_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd(wr_data[7:0]),
    .vpp_lock(vpp_lock), .fail_inject(fail_inject), .status(status),
    .state(seq_state), .commit(seq_commit)
);

// File: tb/bufprog_seq_tb.sv
module bufprog_seq_tb;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int PC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          vpp_lock = 1'b0;
    logic          fail_inject = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [7:0]    status;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [DW-1:0] expm [1 << AW];
    logic [DW-1:0] pend [512];
    bit            pset [512];

    always #2.5 clk = ~clk;

    bufprog_seq #(.PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vpp_lock(vpp_lock), .fail_inject(fail_inject), .rd_addr(rd_addr),
        .rd_data(rd_data), .status(status)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        check(tag, 32'(rd_data), 32'(expm[a]));
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!status[7] && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int seed);
        return DW'(a * 7 + seed * 131 + 5);
    endfunction

    task automatic clear_pend();
        for (int i = 0; i < 512; i++) pset[i] = 1'b0;
    endtask

    task automatic put(input int start, input int off, input logic [DW-1:0] d);
        hw(AW'(start + off), d);
        pend[off] = d; pset[off] = 1'b1;
    endtask

    task automatic apply_pend(input int start, input int n);
        for (int i = 0; i < n; i++) if (pset[i]) expm[start + i] = pend[i];
    endtask

    // full legal run; rev selects descending order for the later writes
    task automatic run_ok(input string tag, input int start, input int n,
                          input int seed, input bit rev);
        int busy;
        clear_pend();
        hw(AW'(start), 16'h00E8);
        hw(AW'(start), DW'(n - 1));
        put(start, 0, pat(start, seed));
        for (int k = 1; k < n; k++) begin
            int off = rev ? n - k : k;
            put(start, off, pat(start + off, seed));
        end
        hw(AW'(start), 16'h00D0);
        wait_ready(busy);
        apply_pend(start, n);
        check({tag, " R3 busy cycles"}, 32'(busy), 32'(n * PC));
        rd_chk({tag, " R2 first word"}, AW'(start));
        rd_chk({tag, " R2 last word"}, AW'(start + n - 1));
        rd_chk({tag, " R2 middle word"}, AW'(start + n / 2));
    endtask

    task automatic t_reset();
        check("R1 reset status", 32'(status), 32'h80);
    endtask

    task automatic t_gap_dup();
        int busy;
        clear_pend();
        hw(AW'(16), 16'h00E8);
        hw(AW'(16), DW'(3));
        put(16, 0, 16'hA000);
        put(16, 2, 16'hA002);
        put(16, 2, 16'hA0F2);
        put(16, 3, 16'hA003);
        hw(AW'(16), 16'h00D0);
        wait_ready(busy);
        apply_pend(16, 4);
        check("R3 gap run busy", 32'(busy), 32'(4 * PC));
        rd_chk("R2 untouched slot keeps old word", AW'(17));
        rd_chk("R2 repeated slot takes last data", AW'(18));
        rd_chk("R2 gap run word 0", AW'(16));
    endtask

    task automatic t_cap();
        clear_pend();
        hw(AW'(12'h1F0), 16'h00E8);
        hw(AW'(12'h1F0), DW'(256));
        hw(AW'(12'h1F0), 16'h5555);
        check("R7 crossing run of 257 rejected", 32'(status), 32'hB0);
        rd_chk("R7 rejected run leaves array", AW'(12'h1F0));
        hw(AW'(0), 16'h0050);
        check("R10 clear after capacity error", 32'(status), 32'h80);
    endtask

    task automatic t_block();
        hw(AW'(12'h3FE), 16'h00E8);
        hw(AW'(12'h3FE), DW'(3));
        hw(AW'(12'h3FE), 16'h1234);
        check("R6 run past erase block rejected", 32'(status), 32'hB0);
        hw(AW'(0), 16'h0050);
        hw(AW'(12'h000), 16'h00E8);
        hw(AW'(12'h000), DW'(1));
        hw(AW'(12'h402), 16'h1234);
        check("R6 start outside setup block rejected", 32'(status), 32'hB0);
        hw(AW'(0), 16'h0050);
        check("R10 clear after block error", 32'(status), 32'h80);
    endtask

    task automatic t_bad_confirm();
        hw(AW'(2), 16'h00E8);
        hw(AW'(2), DW'(1));
        hw(AW'(2), 16'hDEAD);
        hw(AW'(3), 16'hBEEF);
        hw(AW'(2), 16'h00FF);
        check("R4 wrong confirm opcode", 32'(status), 32'hB0);
        rd_chk("R4 array unchanged after bad opcode", AW'(2));
        hw(AW'(0), 16'h0050);
        hw(AW'(2), 16'h00E8);
        hw(AW'(2), DW'(1));
        hw(AW'(2), 16'hDEAD);
        hw(AW'(3), 16'hBEEF);
        hw(AW'(12'h402), 16'h00D0);
        check("R4 confirm in other block", 32'(status), 32'hB0);
        rd_chk("R4 array unchanged after wrong block", AW'(3));
        hw(AW'(0), 16'h0050);
    endtask

    task automatic t_range();
        hw(AW'(12'h100), 16'h00E8);
        hw(AW'(12'h100), DW'(2));
        hw(AW'(12'h100), 16'h0001);
        hw(AW'(12'h103), 16'h0002);
        check("R5 address past start plus count", 32'(status), 32'hB0);
        hw(AW'(0), 16'h0050);
        check("R5 block back in idle after abort", 32'(status), 32'h80);
    endtask

    task automatic t_vpp();
        vpp_lock = 1'b1;
        hw(AW'(0), 16'h00E8);
        check("R8 lockout at setup", 32'(status), 32'h98);
        vpp_lock = 1'b0;
        run_ok("R8 idle after lockout", 32, 4, 9, 1'b0);
        check("R10 voltage bits sticky across run", 32'(status), 32'h98);
        hw(AW'(0), 16'h0050);
        check("R10 clear voltage bits", 32'(status), 32'h80);
    endtask

    task automatic t_fail();
        int busy;
        hw(AW'(16), 16'h00E8);
        hw(AW'(16), DW'(3));
        for (int k = 0; k < 4; k++) hw(AW'(16 + k), 16'hCC00 + DW'(k));
        fail_inject = 1'b1;
        hw(AW'(16), 16'h00D0);
        wait_ready(busy);
        fail_inject = 1'b0;
        check("R9 stop at first commit", 32'(busy), 32'(PC));
        check("R9 program error status", 32'(status), 32'h90);
        rd_chk("R9 failed word not written", AW'(16));
        rd_chk("R9 later word not written", AW'(19));
    endtask

    task automatic t_busy_ignore();
        int busy;
        clear_pend();
        hw(AW'(48), 16'h00E8);
        hw(AW'(48), DW'(3));
        for (int k = 0; k < 4; k++) put(48, k, pat(48 + k, 3));
        hw(AW'(48), 16'h00D0);
        hw(AW'(0), 16'h0050);
        hw(AW'(0), 16'h00E8);
        wait_ready(busy);
        apply_pend(48, 4);
        check("R10 clear while busy ignored", 32'(status), 32'h90);
        rd_chk("R3 run intact despite writes while busy", AW'(49));
        hw(AW'(0), 16'h0050);
        check("R3 no setup captured while busy", 32'(status), 32'h80);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_ok("R2 aligned", 0, 8, 1, 1'b0);
        run_ok("R2 unaligned reverse", 12'h123, 20, 2, 1'b1);
        t_gap_dup();
        run_ok("R7 aligned full buffer", 12'h400, 512, 4, 1'b0);
        run_ok("R7 crossing run of 256", 12'h1F0, 256, 5, 1'b1);
        t_cap();
        t_block();
        t_bad_confirm();
        t_range();
        t_vpp();
        t_fail();
        t_busy_ignore();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule